// File: doc/BRIEF.md
# Converter Serial Result Port

This block is the digital face of a 16-bit successive-approximation converter. A rising edge on the start pin begins a conversion of fixed length, timed by an internal counter in system clock cycles. At that same edge the block samples the chain-input pin and the shift-clock pin to choose how the result will leave the device. Chain input high selects addressed (chip-select) readout. Chain input low selects chained readout. Each readout style can be preceded by a low busy bit or not.

In addressed readout the output floats during conversion. The host selects the device by pulling the start pin low (three-wire wiring) or the chain input low (four-wire wiring). In chained readout the output is driven low from the start of the conversion. After the device's own word, it forwards the bits it collected on its chain input, so several devices can be read through one wire. The result word is supplied on a parallel input and is taken at the cycle the conversion ends. It is sent MSB first as straight binary.

All pins are synchronised to the system clock and edge-detected. The output enable is a separate port that models the tri-state driver.

Top module: `sar_serial_port`

## Requirements
- R1: At a start-pin rising edge, chain input high selects addressed mode (output enable low during conversion) and chain input low selects chained mode (output enable high during conversion).
- R2: In addressed mode the output floats from the start edge, and the conversion lasts CONV_CYCLES clocks whatever the start and chain inputs do afterwards.
- R3: In addressed mode, if the select (start pin low or chain input low) is active when the conversion ends, the output is driven low at once as a busy bit; otherwise the output stays floating.
- R4: Without a busy bit, the MSB appears when select becomes active. Each shift-clock falling edge presents the next lower bit, and the 16th falling edge releases the output.
- R5: With a busy bit, the first shift-clock falling edge presents the MSB, each later one the next lower bit, and the 17th falling edge releases the output.
- R6: In addressed mode, select going inactive during readout releases the output at once, and later shift-clock edges do not re-enable it.
- R7: In chained mode the output is driven low during conversion. A shift clock low at the start edge means no busy bit; a shift clock high means the output stays low (busy) after conversion end until the first falling edge.
- R8: In chained mode, each shift-clock falling edge that shifts data also captures the chain input into the word's LSB. After its own 16 bits, the device outputs the captured bits MSB first. With a busy bit, the first falling edge only ends the busy bit and captures nothing.
- R9: The result word is captured at the conversion-end cycle and sent as 16-bit straight binary: codes 0x0000, 0x8000 and 0xFFFF leave bit for bit, and later changes of the input word do not affect the word being sent.
- R10: Shift-clock falling edges during a conversion do not shift the output word.
- R11: In chained mode, a start-pin falling edge during readout releases the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion start; acts as select in three-wire wiring |
| chain_i | input | 1 | Mode strap at start, select in four-wire wiring, upstream data in chained mode |
| shift_clk_i | input | 1 | Serial shift clock; data changes on its falling edge |
| result_i | input | 16 | Conversion result word, straight binary |
| dout_o | output | 1 | Serial data out (0 while not enabled) |
| dout_oe_o | output | 1 | Output driver enable |

## Verification
The hardest state to reach is the busy-bit decision in addressed mode. The busy bit depends on the select level at the exact conversion-end cycle, not at the start edge. The stimulus raises the start pin with the chain input high, then drops the active select partway through the conversion. In one wiring the select is the start pin, in the other it is the chain input. Shift-clock pulses inside the conversion window show that they do not consume a bit. Chained readout is driven for 32 or 33 falling edges, with upstream bits placed on the chain input at the edges that must capture them. This proves both the capture alignment and the hand-over from the device's own word to the forwarded word.

// File: rtl/sar_port_pkg.sv
package sar_port_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CONV,
    ST_WAIT_SEL,
    ST_READ
  } port_state_e;

  localparam int unsigned PIN_START = 0;
  localparam int unsigned PIN_CHAIN = 1;
  localparam int unsigned PIN_SCLK  = 2;
  localparam int unsigned PIN_COUNT = 3;
endpackage

// File: rtl/sar_pin_sync.sv
module sar_pin_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pins_i,
  output logic [WIDTH-1:0] level_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[s] <= '0;
          else         stage_q[s] <= pins_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[s] <= '0;
          else         stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign level_o = stage_q[STAGES-1];
endmodule

// File: rtl/sar_conv_timer.sv
module sar_conv_timer #(
  parameter int unsigned CYCLES = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= CW'(CYCLES - 1);
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = run_q && (cnt_q == '0);

  // controller must not restart a running conversion
  assert_no_restart_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !run_q);
  assert_count_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cnt_q < CW'(CYCLES)));
endmodule

// File: rtl/sar_out_shifter.sv
module sar_out_shifter #(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned CNT_W = $clog2(WORD_W + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_low_i,
  input  logic              load_i,
  input  logic              load_busy_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              shift_i,
  input  logic              ser_i,
  output logic              bit_o,
  output logic [CNT_W-1:0]  count_o
);
  logic [WORD_W-1:0] sreg_q;
  logic              low_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      low_q  <= 1'b1;
      cnt_q  <= '0;
    end else if (hold_low_i) begin
      low_q <= 1'b1;
      cnt_q <= '0;
    end else if (load_i) begin
      sreg_q <= word_i;
      low_q  <= load_busy_i;
      cnt_q  <= '0;
    end else if (shift_i) begin
      if (cnt_q != CNT_W'(WORD_W + 1)) cnt_q <= cnt_q + 1'b1;
      if (low_q) low_q  <= 1'b0;  // busy edge: no data movement
      else       sreg_q <= {sreg_q[WORD_W-2:0], ser_i};
    end
  end

  assign bit_o   = low_q ? 1'b0 : sreg_q[WORD_W-1];
  assign count_o = cnt_q;

  assert_load_excl_shift_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && shift_i));
  assert_busy_first_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && load_busy_i && !hold_low_i) |=> !bit_o);
endmodule

// File: rtl/sar_serial_port.sv
module sar_serial_port
  import sar_port_pkg::*;
#(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned CONV_CYCLES = 40,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              chain_i,
  input  logic              shift_clk_i,
  input  logic [WORD_W-1:0] result_i,
  output logic              dout_o,
  output logic              dout_oe_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 2);

  logic [PIN_COUNT-1:0] lvl;
  logic                 start_prev_q, sclk_prev_q;
  logic                 start_rise, start_fall, sclk_fall;
  logic                 sel_now;

  port_state_e          state_q;
  logic                 chain_q, busy_q, oe_q;

  logic                 start_go, conv_done, load, load_busy, shift, frame_end;
  logic                 sh_bit;
  logic [CNT_W-1:0]     sh_cnt;

  sar_pin_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pins_i  ({shift_clk_i, chain_i, start_i}),
    .level_o (lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_prev_q <= 1'b0;
      sclk_prev_q  <= 1'b0;
    end else begin
      start_prev_q <= lvl[PIN_START];
      sclk_prev_q  <= lvl[PIN_SCLK];
    end
  end

  assign start_rise = lvl[PIN_START] & ~start_prev_q;
  assign start_fall = ~lvl[PIN_START] & start_prev_q;
  assign sclk_fall  = ~lvl[PIN_SCLK] & sclk_prev_q;
  // select active when either wiring pulls its select pin low
  assign sel_now    = ~(lvl[PIN_START] & lvl[PIN_CHAIN]);

  assign start_go  = start_rise && (state_q != ST_CONV);
  assign load      = (state_q == ST_CONV) && conv_done;
  assign load_busy = chain_q ? busy_q : sel_now;
  assign shift     = (state_q == ST_READ) && sclk_fall && !start_go;
  assign frame_end = shift && !chain_q &&
                     (sh_cnt == CNT_W'(WORD_W - 1) + CNT_W'(busy_q));

  sar_conv_timer #(.CYCLES(CONV_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_go),
    .done_o  (conv_done)
  );

  sar_out_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hold_low_i  (start_go),
    .load_i      (load),
    .load_busy_i (load_busy),
    .word_i      (result_i),
    .shift_i     (shift),
    .ser_i       (lvl[PIN_CHAIN]),
    .bit_o       (sh_bit),
    .count_o     (sh_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      chain_q <= 1'b0;
      busy_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else if (start_go) begin
      state_q <= ST_CONV;
      chain_q <= ~lvl[PIN_CHAIN];
      busy_q  <= ~lvl[PIN_CHAIN] & lvl[PIN_SCLK];
      oe_q    <= ~lvl[PIN_CHAIN];
    end else begin
      unique case (state_q)
        ST_CONV: begin
          if (conv_done) begin
            if (chain_q) begin
              state_q <= ST_READ;
            end else if (sel_now) begin
              busy_q  <= 1'b1;
              oe_q    <= 1'b1;
              state_q <= ST_READ;
            end else begin
              busy_q  <= 1'b0;
              state_q <= ST_WAIT_SEL;
            end
          end
        end
        ST_WAIT_SEL: begin
          if (sel_now) begin
            oe_q    <= 1'b1;
            state_q <= ST_READ;
          end
        end
        ST_READ: begin
          if (chain_q) begin
            if (start_fall) begin
              oe_q    <= 1'b0;
              state_q <= ST_IDLE;
            end
          end else if (!sel_now || frame_end) begin
            oe_q    <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  assign dout_oe_o = oe_q;
  assign dout_o    = oe_q ? sh_bit : 1'b0;

  assert_cs_float_conv_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONV && !chain_q) |-> !dout_oe_o);
  assert_chain_low_conv_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONV && chain_q) |-> (dout_oe_o && !dout_o));
  assert_busy_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONV && conv_done && !chain_q && sel_now && !start_go)
      |=> (dout_oe_o && !dout_o));
  assert_enable_needs_sel_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(dout_oe_o) && !chain_q) |-> $past(sel_now));
  assert_release_deselect_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_READ && !chain_q && !sel_now && !start_go) |=> !dout_oe_o);
endmodule

// File: tb/sar_serial_port_test.sv
module sar_serial_port_test;
  localparam int unsigned CONV = 40;
  localparam int unsigned SETTLE = 6;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start = 1'b0;
  logic        chain = 1'b0;
  logic        sclk = 1'b0;
  logic [15:0] word = 16'h0000;
  logic        dout, oe;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sar_serial_port #(.WORD_W(16), .CONV_CYCLES(CONV)) uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .chain_i     (chain),
    .shift_clk_i (sclk),
    .result_i    (word),
    .dout_o      (dout),
    .dout_oe_o   (oe)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic exp_oe, input logic exp_bit);
    logic [1:0] act, exp;
    act = {oe, oe ? dout : 1'b0};
    exp = {exp_oe, exp_oe ? exp_bit : 1'b0};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {oe,dout} got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic fall_edge();
    sclk = 1'b1; step(SETTLE);
    sclk = 1'b0; step(SETTLE);
  endtask

  task automatic idle_pins(input logic chain_lvl, input logic sclk_lvl);
    start = 1'b0; chain = chain_lvl; sclk = sclk_lvl; step(SETTLE);
  endtask

  // three-wire, no busy: start stays high through conversion
  task automatic t_cs3_nobusy(input logic [15:0] w);
    idle_pins(1'b1, 1'b0);
    word = w;
    start = 1'b1; step(SETTLE);
    check("R1 addressed mode floats", 1'b0, 1'b0);
    step(CONV + 4);
    check("R3 no busy when deselected", 1'b0, 1'b0);
    word = ~w;  // R9: late change must not reach the output
    start = 1'b0; step(SETTLE);
    check("R4 MSB on select", 1'b1, w[15]);
    for (int k = 1; k <= 15; k++) begin
      fall_edge();
      check("R4 R9 data bit", 1'b1, w[15-k]);
    end
    fall_edge();
    check("R4 release after 16th edge", 1'b0, 1'b0);
    start = 1'b1; step(CONV + 10);
    start = 1'b0; step(SETTLE);  // drain: let the extra conversion read out
    for (int k = 1; k <= 16; k++) fall_edge();
  endtask

  // three-wire, busy: start dropped during conversion, clock pulses in conversion
  task automatic t_cs3_busy(input logic [15:0] w);
    idle_pins(1'b1, 1'b0);
    word = w;
    start = 1'b1; step(SETTLE);
    check("R2 floats at start", 1'b0, 1'b0);
    start = 1'b0; step(SETTLE);
    check("R2 conversion ignores start fall", 1'b0, 1'b0);
    fall_edge(); fall_edge();  // R10: inside conversion window
    step(CONV);
    check("R3 busy bit low", 1'b1, 1'b0);
    for (int k = 1; k <= 16; k++) begin
      fall_edge();
      check("R5 R10 data bit", 1'b1, w[16-k]);
    end
    fall_edge();
    check("R5 release after 17th edge", 1'b0, 1'b0);
  endtask

  // four-wire, no busy, early deselect
  task automatic t_cs4_early(input logic [15:0] w);
    idle_pins(1'b1, 1'b0);
    word = w;
    start = 1'b1; step(CONV + 10);
    check("R3 no busy four-wire", 1'b0, 1'b0);
    chain = 1'b0; step(SETTLE);
    check("R4 MSB on chain-pin select", 1'b1, w[15]);
    for (int k = 1; k <= 4; k++) begin
      fall_edge();
      check("R4 data bit four-wire", 1'b1, w[15-k]);
    end
    chain = 1'b1; step(SETTLE);
    check("R6 release on deselect", 1'b0, 1'b0);
    fall_edge();
    check("R6 stays released", 1'b0, 1'b0);
    start = 1'b0; step(SETTLE);
  endtask

  // four-wire, busy
  task automatic t_cs4_busy(input logic [15:0] w);
    idle_pins(1'b1, 1'b0);
    word = w;
    start = 1'b1; step(SETTLE);
    chain = 1'b0; step(CONV + 4);
    check("R3 busy bit four-wire", 1'b1, 1'b0);
    for (int k = 1; k <= 16; k++) begin
      fall_edge();
      check("R5 data bit four-wire", 1'b1, w[16-k]);
    end
    fall_edge();
    check("R5 release four-wire", 1'b0, 1'b0);
    chain = 1'b1; start = 1'b0; step(SETTLE);
  endtask

  task automatic t_chain_nobusy(input logic [15:0] own, input logic [15:0] up);
    idle_pins(1'b0, 1'b0);
    word = own;
    start = 1'b1; step(SETTLE);
    check("R1 R7 chained drives low", 1'b1, 1'b0);
    step(CONV + 4);
    check("R8 own MSB at end", 1'b1, own[15]);
    for (int k = 1; k <= 32; k++) begin
      logic e;
      chain = (k <= 16) ? up[16-k] : 1'b0;
      fall_edge();
      e = (k < 16) ? own[15-k] : (k < 32) ? up[31-k] : 1'b0;
      check("R8 chained stream", 1'b1, e);
    end
    start = 1'b0; step(SETTLE);
    check("R11 release on start fall", 1'b0, 1'b0);
  endtask

  task automatic t_chain_busy(input logic [15:0] own, input logic [15:0] up);
    idle_pins(1'b0, 1'b1);
    word = own;
    start = 1'b1; step(SETTLE);
    check("R7 chained low busy mode", 1'b1, 1'b0);
    step(CONV + 4);
    check("R7 busy bit after end", 1'b1, 1'b0);
    for (int k = 1; k <= 33; k++) begin
      logic e;
      chain = (k >= 2 && k <= 17) ? up[17-k] : 1'b0;
      fall_edge();
      e = (k <= 16) ? own[16-k] : (k <= 32) ? up[32-k] : 1'b0;
      check("R8 chained busy stream", 1'b1, e);
    end
    start = 1'b0; step(SETTLE);
    check("R11 release busy chain", 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    check("R1 reset state", 1'b0, 1'b0);
    rst_ni = 1'b1;
    step(4);
    check("R1 idle after reset", 1'b0, 1'b0);
    t_cs3_nobusy(16'h8000);   // R9 mid-scale
    t_cs3_busy(16'hFFFF);     // R9 full scale
    t_cs4_early(16'hA5C3);
    t_cs4_busy(16'h0000);     // R9 zero
    t_chain_nobusy(16'hC35A, 16'h9E17);
    t_chain_busy(16'h3C81, 16'hB246);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule